// File: doc/BRIEF.md
# Speculative Wait-State Instruction Memory

This block is a read-only memory slave that sits next to a processor's instruction fetch port. The memory behind it is too slow for single-cycle access, so every fetch takes exactly one wait state. The wait indication is pipelined: the value driven in a cycle governs the next data cycle, not the current one. The requester ignores the wait signal whenever it has no access in flight. This lets the slave hold wait high while idle and drop it only in the cycle after it accepts a request.

A two-state machine produces the wait output. The stalling state drives wait high. The releasing state drives it low and lasts one cycle. The address is captured when a request is accepted in the stalling state. The word at that address is read from an internal synchronous array at the end of the releasing cycle. It is presented with a valid strobe in the completion cycle that follows. A new request may be made in that same completion cycle, so back-to-back fetches each cost one wait state. A separate preload port lets the surrounding system or a testbench fill the array.

Top module: `tcmw_slave`

## Requirements
- R1: Out of reset, and in the first cycle after reset is released, `cpu_wait` is 1 and `cpu_rvalid` is 0. This also holds when reset lands in the middle of an access.
- R2: While wait is high and no request is made, `cpu_wait` stays 1 in the following cycle. Wait is driven speculatively while idle.
- R3: A request is a cycle with `cpu_cs`=1 and `cpu_rd`=1. A request made while `cpu_wait` is 1 makes `cpu_wait` 0 in the next cycle.
- R4: `cpu_wait` is 0 for exactly one cycle and then returns to 1, whatever the inputs are.
- R5: A request presented while `cpu_wait` is 0 is ignored. It starts no access, and `cpu_wait` is not dropped again for it.
- R6: `cpu_cs`=1 with `cpu_rd`=0 is not a request. Wait stays 1 and no read completes.
- R7: `cpu_rvalid` is 1 for exactly the one cycle after each cycle with `cpu_wait`=0, and is 0 otherwise. In that cycle `cpu_rdata` equals the array word at the address presented with the accepted request. Addresses 0 and 2^AW-1 are both reachable.
- R8: A request made in a completion cycle is accepted. Idle, request A, idle, request B, idle, idle gives `cpu_wait` = 1,1,0,1,0,1, with A completing in the fourth cycle and B in the sixth.
- R9: `pl_we`=1 writes `pl_wdata` to word `pl_addr` at the clock edge. If the write hits the word being read at the same edge (the edge that ends a wait-low cycle), the completing read returns the old word, and later reads return the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_cs | input | 1 | Chip select from the requester |
| cpu_rd | input | 1 | Read enable from the requester |
| cpu_addr | input | AW | Word address of the fetch |
| cpu_wait | output | 1 | Pipelined wait; applies to the next data cycle |
| cpu_rdata | output | DW | Read data, meaningful when cpu_rvalid is 1 |
| cpu_rvalid | output | 1 | Marks the completion cycle of a fetch |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | AW | Preload word address |
| pl_wdata | input | DW | Preload write data |

## Verification
The bench targets the cases where a wait generator that looks right in a plain trace goes wrong.

- A request offered while wait is low must be ignored. A design that accepted it would produce a second wait-low cycle and an extra completion.
- A request in the completion cycle must be taken. A design that needed an idle cycle between fetches would leave wait high and lose the second read.
- Chip select without read enable must not start a fetch. A design that keyed only on chip select would drop wait for it.
- A preload that hits the address being read at the same edge must not alter the completing read. A write-first array would return the new word one access too early.
- Reset in the middle of a fetch must not let a stale completion strobe through.

// File: rtl/tcmw_pkg.sv
// Package: shared types for the speculative wait-state memory slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tcmw_pkg;

    // Wait generator states: STALL drives wait high, RELEASE drives it low.
    typedef enum logic {
        ST_STALL   = 1'b0,
        ST_RELEASE = 1'b1
    } wait_state_e;

endpackage

// File: rtl/tcmw_wait_fsm.sv
// Module: tcmw_wait_fsm
// Two-state wait generator. In STALL it holds wait high and accepts a
// request. In RELEASE it holds wait low for one cycle and then always
// returns to STALL. Assumes the requester ignores wait while idle and
// keeps its request qualifiers stable around the clock edge.
module tcmw_wait_fsm
    import tcmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic wait_o,
    output logic accept,
    output logic finish
);

    wait_state_e state_q;
    wait_state_e state_d;

    // Next-state choice: leave STALL only on a request; RELEASE lasts one cycle.
    always_comb begin
        state_d = ST_STALL;
        unique case (state_q)
            ST_STALL:   state_d = req ? ST_RELEASE : ST_STALL;
            ST_RELEASE: state_d = ST_STALL;
            default:    state_d = ST_STALL;
        endcase
    end

    // State register with synchronous active-low reset into STALL.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STALL;
        else        state_q <= state_d;
    end

    // Decoded outputs: wait level, request acceptance, access completion.
    always_comb begin
        wait_o = (state_q == ST_STALL);
        accept = (state_q == ST_STALL) && req;
        finish = (state_q == ST_RELEASE);
    end

endmodule

// File: rtl/tcmw_ram.sv
// Module: tcmw_ram
// Word-addressed synchronous array with one read port and one write port.
// The read is registered and read-first: a write to the same word at the
// same edge does not show in the read result. Assumes no reset of contents.
module tcmw_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Write port: store the preload word at the clock edge.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Read port: register the addressed word when a read is enabled.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem_q[raddr];
    end

endmodule

// File: rtl/tcmw_slave.sv
// Module: tcmw_slave
// Instruction memory slave that inserts one wait state into every read.
// Wait is pipelined and speculative. The address is latched on acceptance.
// The word is read at the end of the wait-low cycle and returned with a
// valid strobe in the completion cycle. Assumes read-only use from the
// requester side; the preload port is for filling the array.
module tcmw_slave #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_cs,
    input  logic          cpu_rd,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_wait,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rvalid,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [DW-1:0] pl_wdata
);

    logic          req;
    logic          accept;
    logic          finish;
    logic [AW-1:0] addr_q;
    logic          rvalid_q;

    // Request qualification: both select and read enable are needed.
    always_comb req = cpu_cs && cpu_rd;

    tcmw_wait_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .wait_o (cpu_wait),
        .accept (accept),
        .finish (finish)
    );

    // Address capture: hold the fetch address from acceptance onward.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= cpu_addr;
    end

    // Completion strobe: valid in the cycle after the wait-low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid_q <= 1'b0;
        else        rvalid_q <= finish;
    end

    tcmw_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .re    (finish),
        .raddr (addr_q),
        .rdata (cpu_rdata),
        .we    (pl_we),
        .waddr (pl_addr),
        .wdata (pl_wdata)
    );

    always_comb cpu_rvalid = rvalid_q;

endmodule

// File: rtl/tcmw_slave_chk.sv
// Module: tcmw_slave_chk
// Port-level protocol checks for tcmw_slave, attached with bind.
module tcmw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_cs,
    input logic cpu_rd,
    input logic cpu_wait,
    input logic cpu_rvalid
);

    // R1: the first cycle after reset shows wait high and no valid.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cpu_wait && !cpu_rvalid));

    // R2 and R6: no request while wait is high keeps wait high.
    p_idle_keeps_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && !(cpu_cs && cpu_rd)) |=> cpu_wait);

    // R3: a request while wait is high drops wait next cycle.
    p_req_drops_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && cpu_cs && cpu_rd) |=> !cpu_wait);

    // R4 and R5: wait low lasts a single cycle whatever the inputs.
    p_single_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wait |=> cpu_wait);

    // R7: completion follows every wait-low cycle.
    p_valid_follows_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wait |=> cpu_rvalid);

    // R7: no completion unless the previous cycle had wait low.
    p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_wait) |-> !cpu_rvalid);

endmodule

bind tcmw_slave tcmw_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_cs     (cpu_cs),
    .cpu_rd     (cpu_rd),
    .cpu_wait   (cpu_wait),
    .cpu_rvalid (cpu_rvalid)
);

// File: tb/tcmw_slave_tb.sv
module tcmw_slave_tb;

    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 18;

    // Row: {cs, rd, addr[5:0], exp_wait, exp_valid, exp_addr[5:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b0, 6'd0 },
        {1'b1, 1'b1, 6'd5,  1'b1, 1'b0, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0 },
        {1'b1, 1'b1, 6'd9,  1'b1, 1'b1, 6'd5 },
        {1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b1, 6'd9 },
        {1'b1, 1'b0, 6'd3,  1'b1, 1'b0, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b0, 6'd0 },
        {1'b1, 1'b1, 6'd12, 1'b1, 1'b0, 6'd0 },
        {1'b1, 1'b1, 6'd20, 1'b0, 1'b0, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b1, 6'd12},
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b0, 6'd0 },
        {1'b1, 1'b1, 6'd63, 1'b1, 1'b0, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0 },
        {1'b1, 1'b1, 6'd0,  1'b1, 1'b1, 6'd63},
        {1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b1, 6'd0 },
        {1'b0, 1'b0, 6'd0,  1'b1, 1'b0, 6'd0 }
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_cs = 1'b0;
    logic          cpu_rd = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_wait;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rvalid;
    logic          pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [DW-1:0] pl_wdata = '0;

    logic [DW-1:0] model [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tcmw_slave #(.AW(AW), .DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_cs     (cpu_cs),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .cpu_wait   (cpu_wait),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .pl_we      (pl_we),
        .pl_addr    (pl_addr),
        .pl_wdata   (pl_wdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0, 1, 2, 3, 4, 5: return "R8";
            6, 7:             return "R6";
            9, 10, 11:        return "R5";
            default:          return "R7";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pend;
        logic [AW-1:0] vaddr;
        logic          ew;
        logic          ev;
        logic [DW-1:0] old_w;

        // Preload the array and the bench model, still under reset.
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            model[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507);
            pl_we    = 1'b1;
            pl_addr  = AW'(i);
            pl_wdata = model[i];
        end
        @(negedge clk);
        pl_we = 1'b0;
        // R1: reset state.
        chk("R1 wait in reset", {31'd0, cpu_wait}, 32'd1);
        chk("R1 valid in reset", {31'd0, cpu_rvalid}, 32'd0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            chk({row_tag(i), " wait"}, {31'd0, cpu_wait}, {31'd0, VEC[i][7]});
            chk({row_tag(i), " valid"}, {31'd0, cpu_rvalid}, {31'd0, VEC[i][6]});
            if (VEC[i][6]) chk({row_tag(i), " data"}, cpu_rdata, model[VEC[i][5:0]]);
            cpu_cs   = VEC[i][15];
            cpu_rd   = VEC[i][14];
            cpu_addr = VEC[i][13:8];
        end

        // Random mix of idle cycles and back-to-back requests.
        ew = 1'b1; ev = 1'b0; pend = '0; vaddr = '0;
        for (int c = 0; c < 400; c++) begin
            logic nw;
            @(negedge clk);
            chk("R3 random wait", {31'd0, cpu_wait}, {31'd0, ew});
            chk("R7 random valid", {31'd0, cpu_rvalid}, {31'd0, ev});
            if (ev) chk("R7 random data", cpu_rdata, model[vaddr]);
            cpu_cs   = ($urandom_range(0, 3) != 0);
            cpu_rd   = ($urandom_range(0, 4) != 0);
            cpu_addr = AW'($urandom_range(0, DEPTH - 1));
            ev = !ew;
            if (!ew) vaddr = pend;
            if (ew && cpu_cs && cpu_rd) begin
                nw = 1'b0;
                pend = cpu_addr;
            end else begin
                nw = 1'b1;
            end
            ew = nw;
        end
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // Preload hitting the word being read at the same edge: read-first.
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = 6'd30;
        @(negedge clk);
        chk("R3 collision wait low", {31'd0, cpu_wait}, 32'd0);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
        old_w    = model[30];
        pl_we    = 1'b1; pl_addr = 6'd30; pl_wdata = 32'hDEAD_BEEF;
        model[30] = 32'hDEAD_BEEF;
        @(negedge clk);
        pl_we = 1'b0;
        chk("R9 collision valid", {31'd0, cpu_rvalid}, 32'd1);
        chk("R9 collision old data", cpu_rdata, old_w);
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = 6'd30;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
        @(negedge clk);
        chk("R9 new data", cpu_rdata, 32'hDEAD_BEEF);
        chk("R9 new data valid", {31'd0, cpu_rvalid}, 32'd1);

        // Reset landing in the middle of an access.
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = 6'd7;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
        chk("R3 before reset wait low", {31'd0, cpu_wait}, 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-access reset wait", {31'd0, cpu_wait}, 32'd1);
        chk("R1 mid-access reset valid", {31'd0, cpu_rvalid}, 32'd0);
        @(negedge clk);
        chk("R1 no stale valid", {31'd0, cpu_rvalid}, 32'd0);
        chk("R2 idle after reset", {31'd0, cpu_wait}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule